// File: doc/BRIEF.md
# Exclusive Reservation Monitor

This block tracks load-exclusive / store-exclusive reservations for a group of cores that build locks in shared memory. Every core reports each memory access to it: a valid flag, an access kind, a byte address and a flag saying whether the location is shareable. In return the block gives a pass or fail verdict for every store-exclusive. Memory is written only when the verdict is a pass.

Each core has a private (local) reservation of one word. A separate global table holds one entry per core, and only shareable load-exclusives fill it. A store-exclusive to a non-shareable word is judged on the local reservation alone. A store-exclusive to a shareable word also needs the core's global entry to be intact.

Global entries are cleared by ordinary stores and by winning store-exclusives that come from other cores. A per-core clear pulse drops the local reservation when the operating system switches context. The verdict is registered and appears one clock after the request.

Top module: `excl_monitor`

## Requirements
- R1: After reset no core holds a reservation and `sx_done_o` is all zero. A store-exclusive issued straight after reset fails.
- R2: The access kind of each core is 2 bits: 00 ordinary load, 01 ordinary store, 10 load-exclusive, 11 store-exclusive. For every core that issues a store-exclusive in cycle k, `sx_done_o` is 1 in cycle k+1. `sx_fail_o` carries the verdict in that same cycle, with 0 meaning pass. For any other access, or no access, `sx_done_o` is 0.
- R3: A load-exclusive followed by a store-exclusive from the same core to the same word, with nothing in between, passes.
- R4: Every store-exclusive drops the issuing core's local reservation, whether it passes or fails. A second store-exclusive with no new load-exclusive therefore fails.
- R5: Each core holds only one reservation. A newer load-exclusive replaces the older one, so a store-exclusive to the older word fails and one to the newer word passes.
- R6: Addresses are compared as 32-bit words: byte address bits [1:0] are ignored and the bits above them must match.
- R7: A context-clear pulse drops that core's local reservation. A store-exclusive issued in the same cycle as the pulse, or after it, fails.
- R8: On a shareable word, an ordinary store from another core clears the reservation, so the following store-exclusive fails. An ordinary load from another core leaves the reservation intact.
- R9: On a non-shareable word, accesses from other cores do not affect the reservation.
- R10: A passing shareable store-exclusive clears every other core's global reservation on that word.
- R11: When several cores issue passing-eligible shareable store-exclusives to the same word in one cycle, only the lowest-numbered core passes. Store-exclusives to different words in the same cycle are judged independently.
- R12: A shareable store-exclusive fails if another core issues an ordinary shareable store to the same word in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid_i | input | N_CORES | One access presented by each core |
| acc_kind_i | input | 2*N_CORES | Access kind per core, core c in bits [2c+1:2c] |
| acc_addr_i | input | ADDR_W*N_CORES | Byte address per core, core c in slice c |
| acc_shared_i | input | N_CORES | Access targets a shareable location |
| ctx_clear_i | input | N_CORES | Context-switch pulse that drops the core's local reservation |
| sx_done_o | output | N_CORES | Store-exclusive verdict valid, one cycle after the request |
| sx_fail_o | output | N_CORES | Verdict: 1 fail, 0 pass |

## Verification
Assertions check several rules on every cycle:
- the one-cycle verdict timing;
- that a pass is always backed by a local hit;
- that a store-exclusive or a clear pulse always empties the local monitor;
- that remote writes empty matching global entries;
- that no two cores pass on the same shared word;
- that a same-cycle store race forces a fail.

Only the directed scenarios can show whole reservation histories. These include replacement by a newer load-exclusive, word-granular matching, loads that leave a reservation intact, and non-shareable words that ignore other cores.

// File: rtl/excl_mon_pkg.sv
package excl_mon_pkg;
   typedef enum logic [1:0] {
      ACC_LOAD   = 2'b00,
      ACC_STORE  = 2'b01,
      ACC_LDX    = 2'b10,
      ACC_STX    = 2'b11
   } acc_kind_t;
endpackage

// File: rtl/excl_local_mon.sv
module excl_local_mon #(
   parameter int WA_W = 30
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ldx_i,
   input  logic            stx_i,
   input  logic            clr_i,
   input  logic [WA_W-1:0] waddr_i,
   output logic            hit_o
);
   logic            res_vld;
   logic [WA_W-1:0] res_addr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_vld  <= 1'b0;
         res_addr <= '0;
      end else if (clr_i || stx_i) begin
         res_vld  <= 1'b0;
      end else if (ldx_i) begin
         res_vld  <= 1'b1;
         res_addr <= waddr_i;
      end
   end

   assign hit_o = res_vld && (res_addr == waddr_i);

   assert_stx_empties_R4: assert property (@(posedge clk) disable iff (!rst_n)
      stx_i |=> !res_vld);
   assert_ctx_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> !res_vld);
   assert_newest_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ldx_i && !clr_i && !stx_i) |=> (res_vld && res_addr == $past(waddr_i)));
endmodule

// File: rtl/excl_global_mon.sv
module excl_global_mon #(
   parameter int N    = 4,
   parameter int WA_W = 30
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [N-1:0]            set_i,
   input  logic [N-1:0]            drop_i,
   input  logic [N-1:0]            wr_i,
   input  logic [N-1:0][WA_W-1:0]  waddr_i,
   output logic [N-1:0]            ghit_o
);
   logic [N-1:0]           gv;
   logic [N-1:0][WA_W-1:0] ga;
   logic [N-1:0]           kill;

   always_comb begin
      kill = '0;
      for (int c = 0; c < N; c++) begin
         for (int k = 0; k < N; k++) begin
            if (k != c && wr_i[k] && waddr_i[k] == ga[c]) kill[c] = 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gv <= '0;
         ga <= '0;
      end else begin
         for (int c = 0; c < N; c++) begin
            if (set_i[c]) begin
               gv[c] <= 1'b1;
               ga[c] <= waddr_i[c];
            end else if (drop_i[c] || kill[c]) begin
               gv[c] <= 1'b0;
            end
         end
      end
   end

   for (genvar c = 0; c < N; c++) begin : g_entry
      assign ghit_o[c] = gv[c] && (ga[c] == waddr_i[c]);
      for (genvar k = 0; k < N; k++) begin : g_peer
         if (k != c) begin : g_chk
            // R10 is covered too: winning shared store-exclusives arrive on wr_i
            assert_remote_write_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
               (gv[c] && wr_i[k] && waddr_i[k] == ga[c] && !set_i[c]) |=> !gv[c]);
         end
      end
   end
endmodule

// File: rtl/excl_sx_arbiter.sv
module excl_sx_arbiter #(
   parameter int N    = 4,
   parameter int WA_W = 30
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [N-1:0]            stx_i,
   input  logic [N-1:0]            sh_i,
   input  logic [N-1:0]            clr_i,
   input  logic [N-1:0]            lhit_i,
   input  logic [N-1:0]            ghit_i,
   input  logic [N-1:0]            st_sh_i,
   input  logic [N-1:0][WA_W-1:0]  waddr_i,
   output logic [N-1:0]            win_o
);
   logic [N-1:0] raced;
   logic [N-1:0] cand;
   logic [N-1:0] beaten;

   always_comb begin
      raced = '0;
      for (int c = 0; c < N; c++) begin
         for (int k = 0; k < N; k++) begin
            if (k != c && sh_i[c] && st_sh_i[k] && waddr_i[k] == waddr_i[c]) raced[c] = 1'b1;
         end
      end
      for (int c = 0; c < N; c++) begin
         cand[c] = stx_i[c] && !clr_i[c] && lhit_i[c] &&
                   (!sh_i[c] || (ghit_i[c] && !raced[c]));
      end
      beaten = '0;
      for (int c = 0; c < N; c++) begin
         for (int k = 0; k < c; k++) begin
            if (cand[k] && sh_i[k] && sh_i[c] && waddr_i[k] == waddr_i[c]) beaten[c] = 1'b1;
         end
      end
      win_o = cand & ~beaten;
   end

   for (genvar c = 0; c < N; c++) begin : g_core
      assert_pass_needs_local_R3: assert property (@(posedge clk) disable iff (!rst_n)
         win_o[c] |-> (lhit_i[c] && stx_i[c]));
      for (genvar k = 0; k < c; k++) begin : g_lower
         assert_single_winner_R11: assert property (@(posedge clk) disable iff (!rst_n)
            !(win_o[c] && win_o[k] && sh_i[c] && sh_i[k] && waddr_i[c] == waddr_i[k]));
      end
   end
endmodule

// File: rtl/excl_monitor.sv
module excl_monitor
   import excl_mon_pkg::*;
#(
   parameter int N_CORES    = 4,
   parameter int ADDR_W     = 32,
   parameter int WORD_BYTES = 4
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [N_CORES-1:0]          acc_valid_i,
   input  logic [2*N_CORES-1:0]        acc_kind_i,
   input  logic [ADDR_W*N_CORES-1:0]   acc_addr_i,
   input  logic [N_CORES-1:0]          acc_shared_i,
   input  logic [N_CORES-1:0]          ctx_clear_i,
   output logic [N_CORES-1:0]          sx_done_o,
   output logic [N_CORES-1:0]          sx_fail_o
);
   localparam int GRAN_LSB = $clog2(WORD_BYTES);
   localparam int WA_W     = ADDR_W - GRAN_LSB;

   if (N_CORES < 1 || N_CORES > 16) begin : g_bad_cores
      $error("excl_monitor: N_CORES must be 1..16");
   end
   if ((1 << GRAN_LSB) != WORD_BYTES || WA_W < 1) begin : g_bad_word
      $error("excl_monitor: WORD_BYTES must be a power of two below the address span");
   end

   logic [N_CORES-1:0]            is_ldx, is_stx, is_st;
   logic [N_CORES-1:0][WA_W-1:0]  waddr;
   logic [N_CORES-1:0]            lhit, ghit, win;
   logic [N_CORES-1:0]            st_sh, wr_sh, g_set, g_drop;
   logic [N_CORES-1:0]            done_q, fail_q;
   logic                          unused_addr_bits;

   assign unused_addr_bits = ^acc_addr_i;

   for (genvar c = 0; c < N_CORES; c++) begin : g_core
      acc_kind_t kind;
      assign kind     = acc_kind_t'(acc_kind_i[2*c +: 2]);
      assign is_ldx[c] = acc_valid_i[c] && kind == ACC_LDX;
      assign is_stx[c] = acc_valid_i[c] && kind == ACC_STX;
      assign is_st[c]  = acc_valid_i[c] && kind == ACC_STORE;
      assign waddr[c]  = acc_addr_i[c*ADDR_W + GRAN_LSB +: WA_W];

      excl_local_mon #(.WA_W(WA_W)) u_local (
         .clk     (clk),
         .rst_n   (rst_n),
         .ldx_i   (is_ldx[c]),
         .stx_i   (is_stx[c]),
         .clr_i   (ctx_clear_i[c]),
         .waddr_i (waddr[c]),
         .hit_o   (lhit[c])
      );
   end

   assign st_sh  = is_st & acc_shared_i;
   assign wr_sh  = st_sh | (win & acc_shared_i);
   assign g_set  = is_ldx & acc_shared_i;
   assign g_drop = is_stx | (is_ldx & ~acc_shared_i);

   excl_global_mon #(.N(N_CORES), .WA_W(WA_W)) u_global (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_i   (g_set),
      .drop_i  (g_drop),
      .wr_i    (wr_sh),
      .waddr_i (waddr),
      .ghit_o  (ghit)
   );

   excl_sx_arbiter #(.N(N_CORES), .WA_W(WA_W)) u_arb (
      .clk     (clk),
      .rst_n   (rst_n),
      .stx_i   (is_stx),
      .sh_i    (acc_shared_i),
      .clr_i   (ctx_clear_i),
      .lhit_i  (lhit),
      .ghit_i  (ghit),
      .st_sh_i (st_sh),
      .waddr_i (waddr),
      .win_o   (win)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         done_q <= '0;
         fail_q <= '0;
      end else begin
         done_q <= is_stx;
         fail_q <= is_stx & ~win;
      end
   end

   assign sx_done_o = done_q;
   assign sx_fail_o = fail_q;

   for (genvar c = 0; c < N_CORES; c++) begin : g_chk
      assert_verdict_next_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
         is_stx[c] |=> sx_done_o[c]);
      assert_no_spurious_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
         !is_stx[c] |=> !sx_done_o[c]);
      for (genvar k = 0; k < N_CORES; k++) begin : g_peer
         if (k != c) begin : g_race
            assert_store_race_fails_R12: assert property (@(posedge clk) disable iff (!rst_n)
               (is_stx[c] && acc_shared_i[c] && is_st[k] && acc_shared_i[k] &&
                waddr[k] == waddr[c]) |=> sx_fail_o[c]);
         end
      end
   end
endmodule

// File: tb/excl_monitor_bench.sv
module excl_monitor_bench;
   localparam int N  = 4;
   localparam int AW = 32;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [N-1:0]    vld = '0;
   logic [2*N-1:0]  kind = '0;
   logic [AW*N-1:0] addr = '0;
   logic [N-1:0]    sh = '0;
   logic [N-1:0]    clr = '0;
   logic [N-1:0]    sx_done_o, sx_fail_o;
   logic [N-1:0]    done_s, fail_s;
   int              n_chk = 0;
   int              n_bad = 0;
   bit              reported = 0;

   localparam logic [1:0] K_LD = 2'b00, K_ST = 2'b01, K_LDX = 2'b10, K_STX = 2'b11;
   localparam logic [31:0] A = 32'h0000_1000;
   localparam logic [31:0] B = 32'h0000_1040;

   always #10 clk = ~clk;

   excl_monitor u_excl_monitor (
      .clk(clk), .rst_n(rst_n), .acc_valid_i(vld), .acc_kind_i(kind),
      .acc_addr_i(addr), .acc_shared_i(sh), .ctx_clear_i(clr),
      .sx_done_o(sx_done_o), .sx_fail_o(sx_fail_o));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic op(input int c, input logic [1:0] k, input logic [31:0] a, input logic s);
      vld[c] = 1'b1;
      kind[c*2 +: 2] = k;
      addr[c*AW +: AW] = a;
      sh[c] = s;
   endtask

   task automatic tick();
      @(negedge clk);
      done_s = sx_done_o;
      fail_s = sx_fail_o;
      vld = '0; kind = '0; addr = '0; sh = '0; clr = '0;
   endtask

   task automatic t_reset();
      tick();
      chk("R1 idle done", {28'd0, done_s}, 32'h0);
      for (int c = 0; c < N; c++) op(c, K_STX, A + 32'(c * 64), 1'b0);
      tick();
      chk("R1 fresh stx fails", {28'd0, fail_s}, 32'hF);
      chk("R2 done mask", {28'd0, done_s}, 32'hF);
      tick();
      chk("R2 done one cycle", {28'd0, done_s}, 32'h0);
   endtask

   task automatic t_basic();
      op(0, K_LDX, A, 1'b0); tick();
      chk("R2 ldx no done", {28'd0, done_s}, 32'h0);
      op(0, K_STX, A, 1'b0); tick();
      chk("R2 stx done", {28'd0, done_s}, 32'h1);
      chk("R3 pair passes", {31'd0, fail_s[0]}, 32'h0);
      op(0, K_STX, A, 1'b0); tick();
      chk("R4 second stx fails", {31'd0, fail_s[0]}, 32'h1);
   endtask

   task automatic t_replace();
      op(1, K_LDX, A, 1'b1); tick();
      op(1, K_LDX, B, 1'b1); tick();
      op(1, K_STX, A, 1'b1); tick();
      chk("R5 old word fails", {31'd0, fail_s[1]}, 32'h1);
      op(1, K_LDX, A, 1'b0); tick();
      op(1, K_LDX, B, 1'b0); tick();
      op(1, K_STX, B, 1'b0); tick();
      chk("R5 new word passes", {31'd0, fail_s[1]}, 32'h0);
   endtask

   task automatic t_gran();
      op(2, K_LDX, A, 1'b1); tick();
      op(2, K_STX, A + 32'd3, 1'b1); tick();
      chk("R6 same word passes", {31'd0, fail_s[2]}, 32'h0);
      op(2, K_LDX, A, 1'b1); tick();
      op(2, K_STX, A + 32'd4, 1'b1); tick();
      chk("R6 next word fails", {31'd0, fail_s[2]}, 32'h1);
   endtask

   task automatic t_ctx();
      op(3, K_LDX, A, 1'b0); tick();
      clr[3] = 1'b1; tick();
      op(3, K_STX, A, 1'b0); tick();
      chk("R7 clear before stx", {31'd0, fail_s[3]}, 32'h1);
      op(3, K_LDX, A, 1'b1); tick();
      op(3, K_STX, A, 1'b1); clr[3] = 1'b1; tick();
      chk("R7 clear same cycle", {31'd0, fail_s[3]}, 32'h1);
   endtask

   task automatic t_shared();
      op(0, K_LDX, A, 1'b1); tick();
      op(1, K_LD, A, 1'b1); tick();
      op(0, K_STX, A, 1'b1); tick();
      chk("R8 remote load harmless", {31'd0, fail_s[0]}, 32'h0);
      op(0, K_LDX, A, 1'b1); tick();
      op(1, K_ST, A, 1'b1); tick();
      op(0, K_STX, A, 1'b1); tick();
      chk("R8 remote store kills", {31'd0, fail_s[0]}, 32'h1);
   endtask

   task automatic t_nonshared();
      op(0, K_LDX, B, 1'b0); tick();
      op(1, K_ST, B, 1'b0); tick();
      op(2, K_STX, B, 1'b0); tick();
      op(0, K_STX, B, 1'b0); tick();
      chk("R9 local word untouched", {31'd0, fail_s[0]}, 32'h0);
   endtask

   task automatic t_win_clears();
      op(0, K_LDX, A, 1'b1); op(1, K_LDX, A, 1'b1); tick();
      op(1, K_STX, A, 1'b1); tick();
      chk("R10 first stx passes", {31'd0, fail_s[1]}, 32'h0);
      op(0, K_STX, A, 1'b1); tick();
      chk("R10 loser fails", {31'd0, fail_s[0]}, 32'h1);
   endtask

   task automatic t_same_cycle();
      op(1, K_LDX, A, 1'b1); op(3, K_LDX, A, 1'b1); tick();
      op(1, K_STX, A, 1'b1); op(3, K_STX, A, 1'b1); tick();
      chk("R11 done both", {28'd0, done_s}, 32'hA);
      chk("R11 lower wins", {28'd0, fail_s}, 32'h8);
      op(0, K_LDX, A, 1'b1); op(2, K_LDX, B, 1'b1); tick();
      op(0, K_STX, A, 1'b1); op(2, K_STX, B, 1'b1); tick();
      chk("R11 distinct words both pass", {28'd0, fail_s}, 32'h0);
   endtask

   task automatic t_race();
      op(2, K_LDX, A, 1'b1); tick();
      op(2, K_STX, A, 1'b1); op(0, K_ST, A, 1'b1); tick();
      chk("R12 racing store kills", {31'd0, fail_s[2]}, 32'h1);
   endtask

   task automatic summary();
      if (!reported) begin
         reported = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      end
      $finish;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_basic();
      t_replace();
      t_gran();
      t_ctx();
      t_shared();
      t_nonshared();
      t_win_clears();
      t_same_cycle();
      t_race();
      summary();
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
      summary();
   end
endmodule